// File: doc/BRIEF.md
# Banked GPIO Port with Direction, Data and Output-Enable Registers

This block is a general-purpose I/O port of up to 50 pins controlled through a 16-bit register bus. The lower 32 pins are bidirectional. Each has a direction bit, an output latch and a synchronized input path. Pins from 32 upward are output-only. Their data sits in two upper data registers, and their tri-state enables are controlled in one of two ways, chosen at build time.

The pin count is a build parameter and may be 36, 48 or 50. The parameter `PACKED_EN` picks how the outputs for pins 32 to 47 are enabled:
- With `PACKED_EN=0`, a dedicated enable register holds one bit per pin.
- With `PACKED_EN=1`, these pins have no enable register and always drive their latch.

In both variants, pins 48 and 49 are enabled by bits 8 and 9 of the register that also holds their data.

Software changes single bits by read-modify-write. Every write replaces a whole 16-bit register.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset, every output latch is 0 and every register reads 0. Every pin below 32, and every upper pin of the dedicated variant, has its output enable at 0. With `PACKED_EN=1`, pins 32 to 47 have their output enable fixed at 1.
- R2: A write to offset 0x00 sets `pin_oe[15:0]`, and a write to offset 0x02 sets `pin_oe[31:16]`, on the next clock edge. Bit value 1 means output and 0 means input. Reading either offset returns the stored bits.
- R3: A write to offset 0x04 sets `pin_out[15:0]`, and a write to offset 0x06 sets `pin_out[31:16]`, on the next clock edge.
- R4: A read of offset 0x04 returns the levels of `pin_in[15:0]`, and a read of offset 0x06 returns `pin_in[31:16]`, after a two-flop synchronizer. A level that has been stable for two clock edges is seen by a read issued at the third edge. A read issued at the second edge still returns the old level.
- R5: Offset 0x1C holds the data latches of pins 32 to min(47, count-1), with bit 0 for pin 32. Reads return the latch.
- R6: For a pin count of 50, bits 0 and 1 of offset 0x1E are the data latches of pins 48 and 49. Bits 8 and 9 of the same offset drive `pin_oe[48]` and `pin_oe[49]`.
- R7: With `PACKED_EN=0`, bit n of offset 0x18 drives `pin_oe[32+n]`.
- R8: `reg_rdata` is updated only on the clock edge that samples `reg_rd` high. At other edges it holds its value. Unmapped or odd offsets read 0, and writes to them change nothing.
- R9: When a read and a write of the same register happen in the same cycle, the read returns the contents from before the write.
- R10: Register bits that belong to no pin read 0 and ignore writes. This covers offset 0x1E bits 2 to 7 and 10 to 15, and the bits of 0x1C and 0x18 at or above count-32. With `PACKED_EN=1`, the whole of offset 0x18 reads 0, and writes to it leave the fixed enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 32 | Levels seen on the bidirectional pins |
| pin_out | output | PIN_COUNT | Output latch values |
| pin_oe | output | PIN_COUNT | Tri-state output enables, 1 drives |

## Verification
A read and a write of the same register can fall in the same bus cycle. The same holds for a pin level change and a read of its data register. The bench raises `reg_wr` and `reg_rd` together on offset 0x00 and expects the value from before the write, then reads again and expects the new value. It changes `pin_in` and reads 0x04 at the second and the third edge afterwards, expecting the old level first and the new level second.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_LO,
    SEL_DIR_HI,
    SEL_DAT_LO,
    SEL_DAT_HI,
    SEL_OEN,
    SEL_MID,
    SEL_TOP
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      5'h00:   s = SEL_DIR_LO;
      5'h02:   s = SEL_DIR_HI;
      5'h04:   s = SEL_DAT_LO;
      5'h06:   s = SEL_DAT_HI;
      5'h18:   s = SEL_OEN;
      5'h1C:   s = SEL_MID;
      5'h1E:   s = SEL_TOP;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [REG_W-1:0] low_mask(input int n);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg16.sv
module gpio_reg16
  import gpio_bank_pkg::*;
#(
  parameter logic [REG_W-1:0] KEEP = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wd,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wd & KEEP;
  end

  p_masked_store_r10: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == ($past(wd) & KEEP)));
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] dir_lo,
  input  logic [REG_W-1:0] dir_hi,
  input  logic [REG_W-1:0] lvl_lo,
  input  logic [REG_W-1:0] lvl_hi,
  input  logic [REG_W-1:0] oen,
  input  logic [REG_W-1:0] mid,
  input  logic [REG_W-1:0] top,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] pick;

  always_comb begin
    case (sel)
      SEL_DIR_LO: pick = dir_lo;
      SEL_DIR_HI: pick = dir_hi;
      SEL_DAT_LO: pick = lvl_lo;
      SEL_DAT_HI: pick = lvl_hi;
      SEL_OEN:    pick = oen;
      SEL_MID:    pick = mid;
      SEL_TOP:    pick = top;
      default:    pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= pick;
  end

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT   = 50,
  parameter bit PACKED_EN   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [4:0]           reg_addr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [31:0]          pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  localparam int UPPER_N = PIN_COUNT - 32;
  localparam int MID_N   = (UPPER_N > 16) ? 16 : UPPER_N;
  localparam int TOP_N   = (PIN_COUNT > 48) ? PIN_COUNT - 48 : 0;
  localparam logic [REG_W-1:0] MID_KEEP = low_mask(MID_N);
  localparam logic [REG_W-1:0] OEN_KEEP = PACKED_EN ? '0 : MID_KEEP;
  localparam logic [REG_W-1:0] TOP_KEEP = low_mask(TOP_N) | (low_mask(TOP_N) << 8);

  reg_sel_e         sel;
  logic [REG_W-1:0] dir_lo_q, dir_hi_q, dat_lo_q, dat_hi_q;
  logic [REG_W-1:0] oen_q, mid_q, top_q;
  logic [31:0]      lvl;

  assign sel = decode_offset(reg_addr);

  gpio_reg16 #(.KEEP('1)) u_dir_lo (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_DIR_LO), .wd(reg_wdata), .q(dir_lo_q));
  gpio_reg16 #(.KEEP('1)) u_dir_hi (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_DIR_HI), .wd(reg_wdata), .q(dir_hi_q));
  gpio_reg16 #(.KEEP('1)) u_dat_lo (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_DAT_LO), .wd(reg_wdata), .q(dat_lo_q));
  gpio_reg16 #(.KEEP('1)) u_dat_hi (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_DAT_HI), .wd(reg_wdata), .q(dat_hi_q));
  gpio_reg16 #(.KEEP(OEN_KEEP)) u_oen (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_OEN), .wd(reg_wdata), .q(oen_q));
  gpio_reg16 #(.KEEP(MID_KEEP)) u_mid (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_MID), .wd(reg_wdata), .q(mid_q));
  gpio_reg16 #(.KEEP(TOP_KEEP)) u_top (.clk(clk), .rst(rst),
    .we(reg_wr && sel == SEL_TOP), .wd(reg_wdata), .q(top_q));

  gpio_in_sync #(.W(32), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl));

  gpio_read_port u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .sel(sel),
    .dir_lo(dir_lo_q), .dir_hi(dir_hi_q),
    .lvl_lo(lvl[15:0]), .lvl_hi(lvl[31:16]),
    .oen(oen_q), .mid(mid_q), .top(top_q), .rdata(reg_rdata));

  // bidirectional bank
  assign pin_out[15:0]  = dat_lo_q;
  assign pin_out[31:16] = dat_hi_q;
  assign pin_oe[15:0]   = dir_lo_q;
  assign pin_oe[31:16]  = dir_hi_q;

  // output-only pins 32..47
  assign pin_out[32 +: MID_N] = mid_q[MID_N-1:0];
  generate
    if (PACKED_EN) begin : g_fixed_en
      assign pin_oe[32 +: MID_N] = '1;
    end else begin : g_reg_en
      assign pin_oe[32 +: MID_N] = oen_q[MID_N-1:0];
    end
    if (TOP_N > 0) begin : g_top
      assign pin_out[48 +: TOP_N] = top_q[TOP_N-1:0];
      assign pin_oe[48 +: TOP_N]  = top_q[8 +: TOP_N];
      p_top_en_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 5'h1E) |=> (pin_oe[48] == $past(reg_wdata[8])));
    end
  endgenerate

  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 5'h00) |=> (pin_oe[15:0] == $past(reg_wdata)));
  p_data_write_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 5'h06) |=> (pin_out[31:16] == $past(reg_wdata)));
  p_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_rd && reg_addr == 5'h02) |=> (reg_rdata == $past(pin_oe[31:16])));
endmodule

// File: tb/gpio_bank_port_tb.sv
module gpio_bank_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr0 = 0, rd0 = 0, wr1 = 0, rd1 = 0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] pin_in = '0;
  logic [15:0] rdata0, rdata1;
  logic [49:0] out0, oe0;
  logic [35:0] out1, oe1;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] q0_val[$], q1_val[$];
  string       q0_tag[$], q1_tag[$];

  always #5 clk = ~clk;

  gpio_bank_port #(.PIN_COUNT(50), .PACKED_EN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(wr0), .reg_rd(rd0), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata0), .pin_in(pin_in),
    .pin_out(out0), .pin_oe(oe0));

  gpio_bank_port #(.PIN_COUNT(36), .PACKED_EN(1'b1)) u_dut_pk (
    .clk(clk), .rst(rst), .reg_wr(wr1), .reg_rd(rd1), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata1), .pin_in(pin_in),
    .pin_out(out1), .pin_oe(oe1));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, expected read data pushed to the scoreboard
  task automatic bus(input bit which, input logic [4:0] a, input logic [15:0] d,
                     input bit do_wr, input bit do_rd, input logic [15:0] exp, input string tag);
    addr = a; wdata = d;
    if (which == 0) begin
      wr0 = do_wr; rd0 = do_rd;
      if (do_rd) begin q0_val.push_back(exp); q0_tag.push_back(tag); end
    end else begin
      wr1 = do_wr; rd1 = do_rd;
      if (do_rd) begin q1_val.push_back(exp); q1_tag.push_back(tag); end
    end
    @(negedge clk);
    wr0 = 0; rd0 = 0; wr1 = 0; rd1 = 0;
  endtask

  task automatic wr(input bit which, input logic [4:0] a, input logic [15:0] d);
    bus(which, a, d, 1'b1, 1'b0, 16'h0, "");
  endtask

  task automatic rd(input bit which, input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus(which, a, 16'h0, 1'b0, 1'b1, exp, tag);
  endtask

  // monitors: compare read data after the sampling edge
  initial forever begin
    @(posedge clk);
    if (rd0) begin
      #2;
      check(q0_tag.pop_front(), {48'h0, rdata0}, {48'h0, q0_val.pop_front()});
    end
  end
  initial forever begin
    @(posedge clk);
    if (rd1) begin
      #2;
      check(q1_tag.pop_front(), {48'h0, rdata1}, {48'h0, q1_val.pop_front()});
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe0", {14'h0, oe0}, 64'h0);
    check("R1 out0", {14'h0, out0}, 64'h0);
    check("R1 oe1 fixed upper", {28'h0, oe1}, 64'hF_0000_0000);
    check("R1 out1", {28'h0, out1}, 64'h0);
    rd(0, 5'h00, 16'h0, "R1 dir_lo");
    rd(0, 5'h1E, 16'h0, "R1 top");

    // R2 direction
    wr(0, 5'h00, 16'hA5C3);
    check("R2 oe lo", {48'h0, oe0[15:0]}, 64'hA5C3);
    wr(0, 5'h02, 16'h1234);
    check("R2 oe hi", {48'h0, oe0[31:16]}, 64'h1234);
    rd(0, 5'h02, 16'h1234, "R2 read dir_hi");

    // R3 data latches
    wr(0, 5'h04, 16'hFFFF);
    wr(0, 5'h06, 16'h00F0);
    check("R3 out lo/hi", {32'h0, out0[31:0]}, 64'h00F0_FFFF);

    // R4 synchronized input levels
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    rd(0, 5'h04, 16'hBEEF, "R4 level lo");
    rd(0, 5'h06, 16'hDEAD, "R4 level hi");
    pin_in = 32'h0000_1111;
    @(negedge clk);
    rd(0, 5'h04, 16'hBEEF, "R4 level not yet through");
    rd(0, 5'h04, 16'h1111, "R4 level after two edges");

    // R5 upper data, R7 dedicated enables
    wr(0, 5'h1C, 16'hFFFF);
    check("R5 out 32-47", {48'h0, out0[47:32]}, 64'hFFFF);
    rd(0, 5'h1C, 16'hFFFF, "R5 read mid");
    wr(0, 5'h18, 16'h00FF);
    check("R7 oe 32-47", {48'h0, oe0[47:32]}, 64'h00FF);
    rd(0, 5'h18, 16'h00FF, "R7 read enables");

    // R6 and R10 packed top register
    wr(0, 5'h1E, 16'hFFFF);
    check("R6 out 48-49", {62'h0, out0[49:48]}, 64'h3);
    check("R6 oe 48-49", {62'h0, oe0[49:48]}, 64'h3);
    rd(0, 5'h1E, 16'h0303, "R10 top unused bits");
    wr(0, 5'h1E, 16'h0201);
    check("R6 oe49 only", {62'h0, oe0[49:48]}, 64'h2);
    check("R6 out48 only", {62'h0, out0[49:48]}, 64'h1);

    // R8 unmapped and hold
    wr(0, 5'h08, 16'hFFFF);
    rd(0, 5'h08, 16'h0, "R8 unmapped");
    rd(0, 5'h01, 16'h0, "R8 odd offset");
    check("R8 no side effect oe", {14'h0, oe0}, 64'h2_00FF_1234_A5C3);
    rd(0, 5'h02, 16'h1234, "R8 read before hold");
    repeat (3) @(negedge clk);
    check("R8 rdata holds", {48'h0, rdata0}, 64'h1234);

    // R9 same-cycle read and write
    bus(0, 5'h00, 16'h0F0F, 1'b1, 1'b1, 16'hA5C3, "R9 read old value");
    rd(0, 5'h00, 16'h0F0F, "R9 read new value");

    // R10 packed 36-pin variant
    wr(1, 5'h1C, 16'hFFFF);
    check("R5 pk out 32-35", {60'h0, out1[35:32]}, 64'hF);
    rd(1, 5'h1C, 16'h000F, "R10 pk mid unused");
    wr(1, 5'h18, 16'h0000);
    check("R10 pk enables fixed", {60'h0, oe1[35:32]}, 64'hF);
    rd(1, 5'h18, 16'h0, "R10 pk enable reg reads 0");
    wr(1, 5'h1E, 16'hFFFF);
    rd(1, 5'h1E, 16'h0, "R10 pk top absent");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule